// File: doc/BRIEF.md
# DRAM Access Timing Sequencer

This block sequences the strobes for a single access to a DRAM space on a 16-bit external bus. A request carries a row address, a column address, two byte enables, a read/write flag and a space number in the range 0 to 3. The block then steps through a fixed four-state cycle: precharge, row, first column state, second column state. It drives the row and then the column address on one shared address output. It asserts the row strobe of the addressed space, the upper and lower column strobes and write enable. At the end it returns read data and a one-cycle done pulse.

An optional wait phase can stretch the column phase between its two states. Each space has its own enable bit for this phase. When the bit is clear, the wait input has no effect. A pin-select input chooses which of two output pairs carries the column strobes. A refresh request runs a column-before-row refresh cycle, with a dedicated refresh strobe held low for its whole length. All strobes are active-low.

Top module: `dram_seq`

## Requirements
- R1: An access runs four states after acceptance, in this order: precharge (all strobes high), row, column-1, column-2. The row strobe is low from the row state through column-2. The active column strobes are low from column-1 through column-2.
- R2: When `wait_en_i[space]` is 1, each high sample of `wait_i` at the end of column-1 or of a wait state adds one wait state. During a wait state the strobes and address match column-1.
- R3: When `wait_en_i[space]` is 0, column-2 follows column-1 directly, whatever the level of `wait_i`.
- R4: `addr_o` carries the captured row address outside the column phase, including idle. It carries the captured column address in column-1, in wait states and in column-2.
- R5: With `pin_sel_i`=0 the column strobes appear on the A pair and the B pair stays high. With `pin_sel_i`=1 they appear on the B pair and the A pair stays high.
- R6: During an access only `ras_n_o[space]` goes low. Bit i of `ras_n_o` belongs to space i.
- R7: In a write, `we_n_o` is low during the column phase. The upper column strobe is asserted only if `be_i[1]` is set, and the lower one only if `be_i[0]` is set. In a read, `we_n_o` stays high and both column strobes are asserted.
- R8: A refresh runs four states. `rfsh_n_o` is low in all four. Both column strobes of the selected pair fall in the second state. All four row strobes fall in the third state and stay low through the fourth. `we_n_o` stays high.
- R9: Read data on `dq_i` is captured at the end of column-2 and appears on `rdata_o` together with a one-cycle `done_o` pulse in the following cycle. The same done pulse follows the last refresh state. Requests are taken only while idle, and a refresh request has priority over an access request.
- R10: In a write, `dq_oe_o` is 1 and `dq_o` carries the write data throughout the column phase. Otherwise `dq_oe_o` is 0.
- R11: After reset all strobes are high, `done_o` is 0 and `addr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, taken while idle |
| refresh_req_i | input | 1 | Refresh request, taken while idle, has priority |
| write_i | input | 1 | 1 = write, 0 = read |
| space_i | input | 2 | DRAM space number 0..3 |
| row_i | input | ADDR_W | Row address |
| col_i | input | ADDR_W | Column address |
| be_i | input | 2 | Byte enables: bit1 upper lane, bit0 lower lane |
| wdata_i | input | DATA_W | Write data |
| wait_en_i | input | NUM_SPACES | Per-space wait enable |
| pin_sel_i | input | 1 | Column strobe pair select |
| wait_i | input | 1 | Wait request from the memory side |
| dq_i | input | DATA_W | Data from memory |
| addr_o | output | ADDR_W | Multiplexed row/column address |
| ras_n_o | output | NUM_SPACES | Row strobes, one per space |
| ucas_a_n_o | output | 1 | Upper column strobe, pair A |
| lcas_a_n_o | output | 1 | Lower column strobe, pair A |
| ucas_b_n_o | output | 1 | Upper column strobe, pair B |
| lcas_b_n_o | output | 1 | Lower column strobe, pair B |
| we_n_o | output | 1 | Write enable |
| rfsh_n_o | output | 1 | Refresh strobe |
| dq_o | output | DATA_W | Write data to memory |
| dq_oe_o | output | 1 | Data output enable |
| rdata_o | output | DATA_W | Captured read data |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench drives `wait_i` high during column-1 of a space whose enable bit is clear, while another space's bit is set. A design that reads the wrong enable bit, or ignores it, would grow a wait state there. Multi-cycle waits check that the strobes hold steady and that the cycle ends exactly when `wait_i` drops, which catches an off-by-one in the wait exit. Single-lane writes on both strobe pairs expose a lane or pair swap. Refresh cycles check that the column strobes fall one state before the row strobes, and a simultaneous refresh and access request checks priority. Requests toggled with a different row address in the middle of an access must leave `addr_o` unchanged and must not start a second cycle after the done pulse.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRE,
    ST_ROW,
    ST_C1,
    ST_WAIT,
    ST_C2,
    ST_RPRE,
    ST_RCAS,
    ST_RRAS1,
    ST_RRAS2
  } seq_st_e;
endpackage

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
  import dram_seq_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 16,
  parameter int NUM_SPACES = 4,
  localparam int SPACE_W   = $clog2(NUM_SPACES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               refresh_req_i,
  input  logic               write_i,
  input  logic [SPACE_W-1:0] space_i,
  input  logic [ADDR_W-1:0]  row_i,
  input  logic [ADDR_W-1:0]  col_i,
  input  logic [1:0]         be_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [NUM_SPACES-1:0] wait_en_i,
  input  logic               wait_i,
  input  logic [DATA_W-1:0]  dq_i,
  output seq_st_e            state_o,
  output logic               write_o,
  output logic [SPACE_W-1:0] space_o,
  output logic [1:0]         be_o,
  output logic [ADDR_W-1:0]  row_o,
  output logic [ADDR_W-1:0]  col_o,
  output logic [DATA_W-1:0]  wdata_o,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               done_o
);

  seq_st_e             state_q;
  logic                write_q;
  logic [SPACE_W-1:0]  space_q;
  logic [1:0]          be_q;
  logic [ADDR_W-1:0]   row_q, col_q;
  logic [DATA_W-1:0]   wdata_q, rdata_q;
  logic                done_q;
  logic                wait_ok;

  assign wait_ok = wait_en_i[space_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      write_q <= 1'b0;
      space_q <= '0;
      be_q    <= '0;
      row_q   <= '0;
      col_q   <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (refresh_req_i) begin
            state_q <= ST_RPRE;
          end else if (req_i) begin
            write_q <= write_i;
            space_q <= space_i;
            be_q    <= be_i;
            row_q   <= row_i;
            col_q   <= col_i;
            wdata_q <= wdata_i;
            state_q <= ST_PRE;
          end
        end
        ST_PRE:   state_q <= ST_ROW;
        ST_ROW:   state_q <= ST_C1;
        ST_C1:    state_q <= (wait_ok && wait_i) ? ST_WAIT : ST_C2;
        ST_WAIT:  if (!wait_i) state_q <= ST_C2;
        ST_C2: begin
          if (!write_q) rdata_q <= dq_i;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        ST_RPRE:  state_q <= ST_RCAS;
        ST_RCAS:  state_q <= ST_RRAS1;
        ST_RRAS1: state_q <= ST_RRAS2;
        ST_RRAS2: begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign write_o = write_q;
  assign space_o = space_q;
  assign be_o    = be_q;
  assign row_o   = row_q;
  assign col_o   = col_q;
  assign wdata_o = wdata_q;
  assign rdata_o = rdata_q;
  assign done_o  = done_q;

  a_r1_pre_to_row: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_PRE |=> state_q == ST_ROW);
  a_r1_row_to_c1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_ROW |=> state_q == ST_C1);
  a_r2_wait_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_C1 && wait_en_i[space_q] && wait_i) |=> state_q == ST_WAIT);
  a_r3_no_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_C1 && !wait_en_i[space_q]) |=> state_q == ST_C2);
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  a_r9_busy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != ST_IDLE |=> $stable(row_q) && $stable(col_q) && $stable(space_q));

endmodule

// File: rtl/dram_seq_strobe.sv
module dram_seq_strobe
  import dram_seq_pkg::*;
#(
  parameter int NUM_SPACES = 4,
  localparam int SPACE_W   = $clog2(NUM_SPACES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  seq_st_e            state_i,
  input  logic               write_i,
  input  logic [SPACE_W-1:0] space_i,
  input  logic [1:0]         be_i,
  input  logic               pin_sel_i,
  output logic [NUM_SPACES-1:0] ras_n_o,
  output logic               ucas_a_n_o,
  output logic               lcas_a_n_o,
  output logic               ucas_b_n_o,
  output logic               lcas_b_n_o,
  output logic               we_n_o,
  output logic               rfsh_n_o
);

  logic col_ph, acc_ras, rf_ph, rf_cas, rf_ras;
  logic ucas_on, lcas_on;

  assign col_ph  = (state_i == ST_C1) || (state_i == ST_WAIT) || (state_i == ST_C2);
  assign acc_ras = (state_i == ST_ROW) || col_ph;
  assign rf_ras  = (state_i == ST_RRAS1) || (state_i == ST_RRAS2);
  assign rf_cas  = (state_i == ST_RCAS) || rf_ras;
  assign rf_ph   = (state_i == ST_RPRE) || rf_cas;

  // reads use both lanes, writes only the enabled ones
  assign ucas_on = rf_cas || (col_ph && (!write_i || be_i[1]));
  assign lcas_on = rf_cas || (col_ph && (!write_i || be_i[0]));

  for (genvar i = 0; i < NUM_SPACES; i++) begin : g_ras
    assign ras_n_o[i] = !(rf_ras || (acc_ras && (space_i == SPACE_W'(i))));
  end

  assign ucas_a_n_o = !(ucas_on && !pin_sel_i);
  assign lcas_a_n_o = !(lcas_on && !pin_sel_i);
  assign ucas_b_n_o = !(ucas_on && pin_sel_i);
  assign lcas_b_n_o = !(lcas_on && pin_sel_i);
  assign we_n_o     = !(write_i && col_ph);
  assign rfsh_n_o   = !rf_ph;

  a_r6_one_ras: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rfsh_n_o |-> $countones(~ras_n_o) <= 1);
  a_r7_read_we_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !write_i |-> we_n_o);
  a_r5_pair_b_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_sel_i |-> (ucas_b_n_o && lcas_b_n_o));
  a_r8_cas_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rfsh_n_o && $fell(ras_n_o[0])) |-> $past(!(ucas_a_n_o && ucas_b_n_o)));

endmodule

// File: rtl/dram_seq_addr.sv
module dram_seq_addr
  import dram_seq_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  seq_st_e           state_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] row_i,
  input  logic [ADDR_W-1:0] col_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o
);

  logic col_ph;

  assign col_ph  = (state_i == ST_C1) || (state_i == ST_WAIT) || (state_i == ST_C2);
  assign addr_o  = col_ph ? col_i : row_i;
  assign dq_o    = wdata_i;
  assign dq_oe_o = write_i && col_ph;

endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_seq_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 16,
  parameter int NUM_SPACES = 4,
  localparam int SPACE_W   = $clog2(NUM_SPACES)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  refresh_req_i,
  input  logic                  write_i,
  input  logic [SPACE_W-1:0]    space_i,
  input  logic [ADDR_W-1:0]     row_i,
  input  logic [ADDR_W-1:0]     col_i,
  input  logic [1:0]            be_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic [NUM_SPACES-1:0] wait_en_i,
  input  logic                  pin_sel_i,
  input  logic                  wait_i,
  input  logic [DATA_W-1:0]     dq_i,
  output logic [ADDR_W-1:0]     addr_o,
  output logic [NUM_SPACES-1:0] ras_n_o,
  output logic                  ucas_a_n_o,
  output logic                  lcas_a_n_o,
  output logic                  ucas_b_n_o,
  output logic                  lcas_b_n_o,
  output logic                  we_n_o,
  output logic                  rfsh_n_o,
  output logic [DATA_W-1:0]     dq_o,
  output logic                  dq_oe_o,
  output logic [DATA_W-1:0]     rdata_o,
  output logic                  done_o
);

  seq_st_e            state;
  logic               write_q;
  logic [SPACE_W-1:0] space_q;
  logic [1:0]         be_q;
  logic [ADDR_W-1:0]  row_q, col_q;
  logic [DATA_W-1:0]  wdata_q;

  dram_seq_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SPACES(NUM_SPACES)
  ) u_fsm (
    .clk_i, .rst_ni, .req_i, .refresh_req_i, .write_i, .space_i,
    .row_i, .col_i, .be_i, .wdata_i, .wait_en_i, .wait_i, .dq_i,
    .state_o(state), .write_o(write_q), .space_o(space_q), .be_o(be_q),
    .row_o(row_q), .col_o(col_q), .wdata_o(wdata_q),
    .rdata_o, .done_o
  );

  dram_seq_strobe #(.NUM_SPACES(NUM_SPACES)) u_strobe (
    .clk_i, .rst_ni, .state_i(state), .write_i(write_q), .space_i(space_q),
    .be_i(be_q), .pin_sel_i, .ras_n_o, .ucas_a_n_o, .lcas_a_n_o,
    .ucas_b_n_o, .lcas_b_n_o, .we_n_o, .rfsh_n_o
  );

  dram_seq_addr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_addr (
    .state_i(state), .write_i(write_q), .row_i(row_q), .col_i(col_q),
    .wdata_i(wdata_q), .addr_o, .dq_o, .dq_oe_o
  );

  a_r10_oe_with_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> !we_n_o);
  a_r1_cas_in_ras: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rfsh_n_o && !(ucas_a_n_o && lcas_a_n_o && ucas_b_n_o && lcas_b_n_o))
      |-> !(&ras_n_o));
  a_r8_rfsh_quiet_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rfsh_n_o |-> we_n_o && !dq_oe_o);

endmodule

// File: tb/dram_seq_bench.sv
`timescale 1ns/1ps
module dram_seq_bench;
  localparam int AW = 10;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_i = 0, refresh_req_i = 0, write_i = 0, pin_sel_i = 0, wait_i = 0;
  logic [1:0] space_i = 0, be_i = 0;
  logic [AW-1:0] row_i = 0, col_i = 0;
  logic [DW-1:0] wdata_i = 0, dq_i = 0;
  logic [3:0] wait_en_i = 0;
  logic [AW-1:0] addr_o;
  logic [3:0] ras_n_o;
  logic ucas_a_n_o, lcas_a_n_o, ucas_b_n_o, lcas_b_n_o, we_n_o, rfsh_n_o;
  logic [DW-1:0] dq_o, rdata_o;
  logic dq_oe_o, done_o;

  int checks = 0, errors = 0;
  bit finished = 0;

  int g_sp; logic [1:0] g_be; logic g_wr, g_ps;
  logic [AW-1:0] g_row = 0, g_col = 0;
  logic [DW-1:0] g_wdata = 0;

  always #2 clk = ~clk;

  dram_seq u_dram_seq (
    .clk_i(clk), .rst_ni, .req_i, .refresh_req_i, .write_i, .space_i,
    .row_i, .col_i, .be_i, .wdata_i, .wait_en_i, .pin_sel_i, .wait_i, .dq_i,
    .addr_o, .ras_n_o, .ucas_a_n_o, .lcas_a_n_o, .ucas_b_n_o, .lcas_b_n_o,
    .we_n_o, .rfsh_n_o, .dq_o, .dq_oe_o, .rdata_o, .done_o
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // kind: 0 idle, 1 precharge, 2 row, 3 column/wait, 4 ref-pre, 5 ref-cas, 6 ref-ras
  function automatic logic [9:0] exp_vec(int kind);
    logic [3:0] ras; logic u, l, we, rf;
    ras = 4'hF; u = 0; l = 0; we = 1; rf = 1;
    case (kind)
      2: ras[g_sp] = 0;
      3: begin
        ras[g_sp] = 0;
        u  = g_wr ? g_be[1] : 1'b1;
        l  = g_wr ? g_be[0] : 1'b1;
        we = !g_wr;
      end
      4: rf = 0;
      5: begin rf = 0; u = 1; l = 1; end
      6: begin rf = 0; u = 1; l = 1; ras = 4'h0; end
      default: ;
    endcase
    return {ras, g_ps ? 1'b1 : ~u, g_ps ? 1'b1 : ~l,
            g_ps ? ~u : 1'b1, g_ps ? ~l : 1'b1, we, rf};
  endfunction

  task automatic step(string tag, int kind, logic exp_done, logic drv_wait, logic [DW-1:0] drv_dq);
    logic oe;
    oe = g_wr && (kind == 3);
    chk(tag, "strobes", {22'd0, ras_n_o, ucas_a_n_o, lcas_a_n_o, ucas_b_n_o,
        lcas_b_n_o, we_n_o, rfsh_n_o}, {22'd0, exp_vec(kind)});
    chk("R4", "addr", 32'(addr_o), 32'((kind == 3) ? g_col : g_row));
    chk("R9", "done", 32'(done_o), 32'(exp_done));
    chk("R10", "dq_oe", 32'(dq_oe_o), 32'(oe));
    if (oe) chk("R10", "dq_o", 32'(dq_o), 32'(g_wdata));
    wait_i = drv_wait;
    dq_i = drv_dq;
    @(negedge clk);
  endtask

  task automatic do_access(int sp, logic wr, logic [1:0] be, logic [AW-1:0] row,
                           logic [AW-1:0] col, logic [DW-1:0] wd, logic ps,
                           logic [3:0] wen, int nwait, logic force_wait,
                           logic [DW-1:0] rd, logic stray);
    g_sp = sp; g_wr = wr; g_be = be; g_row = row; g_col = col; g_wdata = wd; g_ps = ps;
    wait_en_i = wen; pin_sel_i = ps; space_i = 2'(sp); write_i = wr; be_i = be;
    row_i = row; col_i = col; wdata_i = wd; req_i = 1;
    @(negedge clk);
    req_i = 0;
    step("R1", 1, 0, 0, 0);
    step("R6", 2, 0, 0, 0);
    if (stray) begin
      req_i = 1; refresh_req_i = 1; row_i = ~row; space_i = 2'(sp + 1);
    end
    step(wr ? "R7" : "R5", 3, 0, (nwait > 0) || force_wait, 0);
    for (int k = 0; k < nwait; k++) step("R2", 3, 0, k < nwait - 1, 0);
    step(force_wait ? "R3" : "R1", 3, 0, 0, rd);
    if (stray) begin req_i = 0; refresh_req_i = 0; end
    if (!wr) chk("R9", "rdata", 32'(rdata_o), 32'(rd));
    step("R9", 0, 1, 0, 0);
    step("R9", 0, 0, 0, 0);
  endtask

  task automatic do_refresh(logic ps, logic with_req);
    g_ps = ps; g_wr = 0; pin_sel_i = ps;
    refresh_req_i = 1; req_i = with_req; row_i = ~g_row;
    @(negedge clk);
    refresh_req_i = 0; req_i = 0;
    step("R8", 4, 0, 0, 0);
    step("R8", 5, 0, 0, 0);
    step("R8", 6, 0, 0, 0);
    step("R8", 6, 0, 0, 0);
    step("R9", 0, 1, 0, 0);
    step("R9", 0, 0, 0, 0);
  endtask

  initial begin
    g_sp = 0; g_wr = 0; g_be = 0; g_ps = 0;
    repeat (3) @(negedge clk);
    step("R11", 0, 0, 0, 0);
    rst_ni = 1;
    @(negedge clk);
    step("R11", 0, 0, 0, 0);
    // read, pair A, no wait
    do_access(0, 0, 2'b11, 10'h155, 10'h0AA, 16'h0, 0, 4'h0, 0, 0, 16'hBEEF, 0);
    // write both lanes, pair B
    do_access(1, 1, 2'b11, 10'h301, 10'h102, 16'h1234, 1, 4'h0, 0, 0, 16'h0, 0);
    // lower lane write with two waits
    do_access(2, 1, 2'b01, 10'h011, 10'h022, 16'hA5A5, 0, 4'h4, 2, 0, 16'h0, 0);
    // upper lane write, pair B, wait ignored for this space (R3)
    do_access(3, 1, 2'b10, 10'h3FF, 10'h200, 16'h5A5A, 1, 4'h7, 0, 1, 16'h0, 0);
    // space 0 disabled while others enabled (R3)
    do_access(0, 0, 2'b00, 10'h0F0, 10'h00F, 16'h0, 0, 4'hE, 0, 1, 16'hC3C3, 0);
    // read with one wait and stray requests while busy (R9)
    do_access(3, 0, 2'b11, 10'h2A2, 10'h1B1, 16'h0, 1, 4'h8, 1, 0, 16'h7E81, 1);
    do_refresh(0, 0);
    do_refresh(1, 1);
    do_access(1, 0, 2'b11, 10'h123, 10'h321, 16'h0, 0, 4'h2, 3, 0, 16'h0F0F, 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule